// File: doc/BRIEF.md
# Stallable Pipelined Multiplier with Aligned Sideband

This block multiplies two unsigned 32-bit operands and returns the full 64-bit product three clock edges later. It is built for a pixel datapath. A sideband word, such as the sync and blanking flags of a video stream, enters with the operands and travels through the same stage registers. It therefore leaves on the same cycle as the product it belongs to.

The arithmetic is split so that no stage does more than a small amount of work. Each operand is cut into two 16-bit halves. The first stage registers the four half-by-half products. The second stage adds the two cross terms. The third stage merges the high, cross and low parts into the final 64-bit result. A single stall input freezes every stage at once, so the valid flag, the data and the sideband stay aligned.

The latency is published as a package constant. Surrounding logic can size a matching delay line for any path that bypasses the multiplier.

Top module: `pmul_sb_top`

## Requirements
- R1: Whenever out_valid is 1, out_prod equals the unsigned 64-bit product of the in_a and in_b values accepted with that entry.
- R2: The package constant PMUL_LATENCY is 3. An input accepted at one unstalled clock edge is presented at the outputs after exactly 3 unstalled edges, counting the accepting edge.
- R3: out_valid is 1 exactly when an entry accepted with in_valid = 1 reaches the output stage. Cycles accepted with in_valid = 0 appear as out_valid = 0, and entries are never lost, duplicated or reordered.
- R4: out_side equals the in_side word accepted with the same entry, on the same cycle as its product.
- R5: While stall is 1, in_valid, in_a, in_b and in_side are ignored, and out_valid, out_prod and out_side keep their values. Every internal stage also holds, so the sequence resumes intact after stall falls.
- R6: An asynchronous active-low reset (rst_n = 0) clears every valid bit. out_valid is 0 during reset and stays 0 after release until a new valid entry has passed through the pipeline; entries in flight when reset arrived never appear.
- R7: Corner operands give exact products with full carry propagation across the 16-bit boundaries: zero, 0xFFFFFFFF, 0x0000FFFF and 0xFFFF0000 in every pairing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside |
| stall | input | 1 | Freezes all stages when 1 |
| in_valid | input | 1 | Operands and sideband are a real entry |
| in_a | input | 32 | Unsigned multiplicand |
| in_b | input | 32 | Unsigned multiplier |
| in_side | input | 8 | Sideband word carried with the entry |
| out_valid | output | 1 | Output entry is real |
| out_prod | output | 64 | Unsigned product |
| out_side | output | 8 | Sideband word of the output entry |

## Verification
The assertions check on every cycle that each stage and the outputs hold under stall. After three unstalled edges, they check that the output valid, the product and the sideband equal the inputs from three edges before. Only the bench scenarios can show that no entry is lost or reordered across long random stall patterns. The same holds for entries flushed by a reset in mid-stream, and for the exact carries produced by the corner operand pairs. The scoreboard covers these through its ordered queue and its own model of valid timing.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  // Number of register stages between operand capture and result.
  localparam int PMUL_LATENCY = 3;
  localparam int PMUL_OPW     = 32;
  localparam int PMUL_SBW     = 8;
endpackage

// File: rtl/pmul_pp_stage.sv
// Stage 1: four half-width partial products, valid and sideband.
module pmul_pp_stage #(
  parameter int OPW = 32,
  parameter int SBW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stall,
  input  logic                      in_valid,
  input  logic [OPW-1:0]            in_a,
  input  logic [OPW-1:0]            in_b,
  input  logic [SBW-1:0]            in_side,
  output logic                      valid_1,
  output logic [3:0][OPW-1:0]       pp_1,
  output logic [SBW-1:0]            side_1
);
  localparam int H = OPW / 2;

  logic [3:0][OPW-1:0] pp_d;
  logic                adv;

  assign adv = !stall;

  // Index bit 1 selects the half of a, bit 0 the half of b:
  // 0 = lo*lo, 1 = lo*hi, 2 = hi*lo, 3 = hi*hi.
  for (genvar i = 0; i < 4; i++) begin : g_pp
    logic [H-1:0] ah, bh;
    assign ah = (i >= 2)     ? in_a[OPW-1:H] : in_a[H-1:0];
    assign bh = (i % 2 == 1) ? in_b[OPW-1:H] : in_b[H-1:0];
    always_comb pp_d[i] = OPW'(ah) * OPW'(bh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   valid_1 <= 1'b0;
    else if (adv) valid_1 <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      pp_1   <= pp_d;
      side_1 <= in_side;
    end
  end

  assert_s1_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(valid_1) && $stable(pp_1) && $stable(side_1)));
endmodule

// File: rtl/pmul_cross_stage.sv
// Stage 2: sum of the cross terms; outer terms copied forward.
module pmul_cross_stage #(
  parameter int OPW = 32,
  parameter int SBW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stall,
  input  logic                 valid_1,
  input  logic [3:0][OPW-1:0]  pp_1,
  input  logic [SBW-1:0]       side_1,
  output logic                 valid_2,
  output logic [OPW-1:0]       ll_2,
  output logic [OPW:0]         cross_2,
  output logic [OPW-1:0]       hh_2,
  output logic [SBW-1:0]       side_2
);
  logic [OPW:0] cross_d;
  logic         adv;

  assign adv = !stall;

  always_comb cross_d = {1'b0, pp_1[1]} + {1'b0, pp_1[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   valid_2 <= 1'b0;
    else if (adv) valid_2 <= valid_1;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      ll_2    <= pp_1[0];
      cross_2 <= cross_d;
      hh_2    <= pp_1[3];
      side_2  <= side_1;
    end
  end

  assert_s2_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(valid_2) && $stable(cross_2) && $stable(side_2)));
endmodule

// File: rtl/pmul_merge_stage.sv
// Stage 3: merge high, cross and low parts into the full product.
module pmul_merge_stage #(
  parameter int OPW = 32,
  parameter int SBW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stall,
  input  logic                 valid_2,
  input  logic [OPW-1:0]       ll_2,
  input  logic [OPW:0]         cross_2,
  input  logic [OPW-1:0]       hh_2,
  input  logic [SBW-1:0]       side_2,
  output logic                 valid_3,
  output logic [2*OPW-1:0]     prod_3,
  output logic [SBW-1:0]       side_3
);
  localparam int PW = 2 * OPW;
  localparam int H  = OPW / 2;

  logic [PW-1:0] prod_d;
  logic          adv;

  assign adv = !stall;

  always_comb prod_d = {hh_2, ll_2} + (PW'(cross_2) << H);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   valid_3 <= 1'b0;
    else if (adv) valid_3 <= valid_2;
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      prod_3 <= prod_d;
      side_3 <= side_2;
    end
  end

  assert_s3_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(valid_3) && $stable(prod_3) && $stable(side_3)));
endmodule

// File: rtl/pmul_sb_top.sv
module pmul_sb_top
  import pmul_pkg::*;
#(
  parameter int OPW = PMUL_OPW,
  parameter int SBW = PMUL_SBW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall,
  input  logic               in_valid,
  input  logic [OPW-1:0]     in_a,
  input  logic [OPW-1:0]     in_b,
  input  logic [SBW-1:0]     in_side,
  output logic               out_valid,
  output logic [2*OPW-1:0]   out_prod,
  output logic [SBW-1:0]     out_side
);
  localparam int PW = 2 * OPW;

  logic                valid_1, valid_2;
  logic [3:0][OPW-1:0] pp_1;
  logic [SBW-1:0]      side_1, side_2;
  logic [OPW-1:0]      ll_2, hh_2;
  logic [OPW:0]        cross_2;

  pmul_pp_stage #(.OPW(OPW), .SBW(SBW)) u_s1 (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .in_valid(in_valid), .in_a(in_a), .in_b(in_b), .in_side(in_side),
    .valid_1(valid_1), .pp_1(pp_1), .side_1(side_1)
  );

  pmul_cross_stage #(.OPW(OPW), .SBW(SBW)) u_s2 (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .valid_1(valid_1), .pp_1(pp_1), .side_1(side_1),
    .valid_2(valid_2), .ll_2(ll_2), .cross_2(cross_2), .hh_2(hh_2),
    .side_2(side_2)
  );

  pmul_merge_stage #(.OPW(OPW), .SBW(SBW)) u_s3 (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .valid_2(valid_2), .ll_2(ll_2), .cross_2(cross_2), .hh_2(hh_2),
    .side_2(side_2),
    .valid_3(out_valid), .prod_3(out_prod), .side_3(out_side)
  );

  // Edges seen since reset, saturating; guards the three-deep $past.
  logic [1:0] chk_age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              chk_age <= 2'd0;
    else if (chk_age != 2'd3) chk_age <= chk_age + 2'd1;
  end

  logic run3;
  assign run3 = (chk_age == 2'd3);

  assert_latency_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run3 && !$past(stall) && !$past(stall, 2) && !$past(stall, 3))
      |-> (out_valid == $past(in_valid, 3)));

  assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run3 && !$past(stall) && !$past(stall, 2) && !$past(stall, 3) && out_valid)
      |-> (out_prod == PW'($past(in_a, 3)) * PW'($past(in_b, 3))));

  assert_sideband_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run3 && !$past(stall) && !$past(stall, 2) && !$past(stall, 3) && out_valid)
      |-> (out_side == $past(in_side, 3)));
endmodule

// File: tb/test_pmul_sb_top.sv
`timescale 1ns/1ps
module test_pmul_sb_top;
  import pmul_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_a = '0, in_b = '0;
  logic [7:0]  in_side = '0;
  logic        out_valid;
  logic [63:0] out_prod;
  logic [7:0]  out_side;

  always #4 clk = ~clk;   // 125 MHz

  pmul_sb_top i_pmul_sb_top (
    .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_side(in_side),
    .out_valid(out_valid), .out_prod(out_prod), .out_side(out_side)
  );

  int n_cmp = 0, n_bad = 0;
  logic [71:0] sb_q[$];          // {product, sideband} in acceptance order
  logic [2:0]  vmod = '0;        // bench model of valid timing
  logic        last_stall = 1'b0;
  logic        mon_on = 1'b0;
  logic        done = 1'b0;
  logic        p_v; logic [63:0] p_p; logic [7:0] p_s;
  string       tag = "R1";

  task automatic check(input bit ok, input string req, input logic [71:0] act,
                       input logic [71:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Driver: drives at the falling edge, records acceptance at the rising edge.
  task automatic drive(input bit v, input logic [31:0] a, input logic [31:0] b,
                       input logic [7:0] s, input bit st);
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_side = s; stall = st;
    @(posedge clk);
    last_stall = st;
    if (!st) begin
      vmod = {vmod[1:0], v};
      if (v) sb_q.push_back({64'(a) * 64'(b), s});
    end
  endtask

  // Monitor: compares at the falling edge after each rising edge.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (last_stall) begin
          check(out_valid == p_v && out_prod == p_p && out_side == p_s,
                "R5 hold", {out_prod, out_side}, {p_p, p_s});
        end
        check(out_valid == vmod[2], "R3 valid timing (R2 latency)",
              72'(out_valid), 72'(vmod[2]));
        if (out_valid && !last_stall) begin
          if (sb_q.size() == 0) check(1'b0, "R3 extra output", 72'(1), 72'(0));
          else begin
            logic [71:0] e;
            e = sb_q.pop_front();
            check(out_prod == e[71:8], tag, 72'(out_prod), 72'(e[71:8]));
            check(out_side == e[7:0], "R4 sideband", 72'(out_side), 72'(e[7:0]));
          end
        end
      end
      p_v = out_valid; p_p = out_prod; p_s = out_side;
    end
  end

  initial begin
    logic [31:0] corner [4];
    corner[0] = 32'h0; corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h0000_FFFF; corner[3] = 32'hFFFF_0000;

    // R6: reset state
    #3;
    check(out_valid == 1'b0, "R6 reset", 72'(out_valid), 72'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(out_valid == 1'b0, "R6 after release", 72'(out_valid), 72'(0));
    check(PMUL_LATENCY == 3, "R2 constant", 72'(PMUL_LATENCY), 72'(3));
    mon_on = 1'b1;

    // R7: corner pairs, no stall
    tag = "R7 corner";
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        drive(1'b1, corner[i], corner[j], 8'(i * 4 + j), 1'b0);
    repeat (4) drive(1'b0, 32'h0, 32'h0, 8'h0, 1'b0);

    // R1, R3: random operands with bubbles, no stall
    tag = "R1 product";
    for (int k = 0; k < 200; k++)
      drive(($urandom % 4) != 0, $urandom, $urandom, 8'($urandom), 1'b0);

    // R5: random stall patterns, including long stalls
    tag = "R1 product (R5 stalls)";
    for (int k = 0; k < 2000; k++)
      drive(($urandom % 3) != 0, $urandom, $urandom, 8'($urandom),
            (k % 97 > 80) ? 1'b1 : (($urandom % 3) == 0));
    repeat (4) drive(1'b0, 32'h0, 32'h0, 8'h0, 1'b0);

    // R6: reset with entries in flight
    drive(1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 8'hA5, 1'b0);
    drive(1'b1, 32'hFFFF_FFFF, 32'h2, 8'h5A, 1'b0);
    @(negedge clk);
    mon_on = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    check(out_valid == 1'b0, "R6 mid-run reset", 72'(out_valid), 72'(0));
    sb_q.delete(); vmod = '0;
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (5) drive(1'b0, 32'h0, 32'h0, 8'h0, 1'b0);
    check(sb_q.size() == 0, "R6 flushed", 72'(sb_q.size()), 72'(0));

    // R3: tail drains completely
    tag = "R1 product";
    for (int k = 0; k < 50; k++)
      drive(1'b1, $urandom, $urandom, 8'($urandom), ($urandom % 2) == 0);
    repeat (6) drive(1'b0, 32'h0, 32'h0, 8'h0, 1'b0);
    @(negedge clk);
    check(sb_q.size() == 0, "R3 all entries delivered", 72'(sb_q.size()), 72'(0));
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=running exp=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule